// File: doc/BRIEF.md
# Level-Crossing Converter Step Sequencer

This block is the digital control core of a level-crossing analog-to-digital converter. Two comparators watch the difference between the analog input and the level of a capacitor DAC. One reports that the input has risen a full step above that level. The other reports that it has dropped a full step below it. The block takes both comparator outputs asynchronously and keeps the DAC code that follows the input. For every crossing it emits a single-cycle direction event, which is the converter's output data.

Each crossing starts a short, self-contained sequence. An oscillator enable is raised and an edge counter runs. From the count the block forms four non-overlapping phases: a reference-store phase, an offset-store phase, a normal-operation phase and a reset phase. These drive the switched-capacitor offset cancellation around the comparators. When the count completes, the oscillator is gated off. Without crossings nothing toggles.

If a comparator is still high once a sequence has ended, the block returns to idle for one cycle and then starts again. A comparator stuck high therefore produces a stream of events instead of freezing the loop. The DAC code saturates at both ends of its range.

Top module: `lcs_ctrl`

## Requirements
- R1: A rising-crossing input (`cmp_up_a`) that is high at a clock edge while the block is idle produces a one-cycle `ev_up` pulse. This happens three rising edges later: two synchronizer stages plus the decision edge. On that same edge `dac_code` increments by one.
- R2: A falling-crossing input (`cmp_dn_a`) behaves the same way and produces a one-cycle `ev_dn` pulse, with `dac_code` decrementing by one on the same edge.
- R3: `dac_code` saturates. An up event at 63 leaves it at 63, and a down event at 0 leaves it at 0. The event pulse is still emitted in both cases.
- R4: `osc_en` goes high on the edge that emits an event. It stays high for exactly SEQ = 4*(PH_LEN+GAP)+GAP cycles, which is 17 with the defaults, and then stays low for at least one cycle before any later sequence.
- R5: Counting cycles from the event cycle as offset 0, phase k is high exactly for offsets k*(PH_LEN+GAP)+GAP up to k*(PH_LEN+GAP)+GAP+PH_LEN-1. With the defaults these are offsets 1-3, 5-7, 9-11 and 13-15. The order is k=0 `ph_ref`, k=1 `ph_ofs`, k=2 `ph_norm`, k=3 `ph_rst`. At most one phase is high at any time.
- R6: While no sequence runs, `osc_en` and all four phases stay low.
- R7: A comparator input held high re-triggers a sequence every SEQ+1 cycles, for as long as it is sampled high two edges before a possible start. Each retrigger emits one event and one code step.
- R8: If both comparator inputs are sampled high together, only the up event is served. The down request is ignored for that sequence.
- R9: After synchronous active-low reset, `dac_code` equals INIT_CODE (32 by default), and `osc_en`, the four phases and both event outputs are 0.
- R10: A comparator pulse that reaches the decision stage while a sequence is still running and is gone by the time the block is idle causes no event and no change of `dac_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, standing in for the gated oscillator edges |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_up_a | input | 1 | Asynchronous comparator output: input one step above DAC level |
| cmp_dn_a | input | 1 | Asynchronous comparator output: input one step below DAC level |
| osc_en | output | 1 | Oscillator gate, high while a step sequence runs |
| ph_ref | output | 1 | Reference-store phase |
| ph_ofs | output | 1 | Offset-store phase |
| ph_norm | output | 1 | Normal-operation phase |
| ph_rst | output | 1 | Reset phase |
| dac_code | output | 6 | DAC code tracking the input |
| ev_up | output | 1 | One-cycle rising-crossing event |
| ev_dn | output | 1 | One-cycle falling-crossing event |

## Verification
An event and its code step are due on the third rising edge after a comparator input is first sampled high. The oscillator gate and each phase then follow at fixed offsets from that event cycle, and a held comparator repeats every SEQ+1 cycles. The driver stamps every expected event with the bench cycle number on which it must appear. The monitor samples on falling edges and compares the event direction, the code and that exact cycle. From the most recent event it also recomputes the expected gate and phase levels for every cycle. As a result, an event that arrives early, late or with no stimulus behind it fails, and so does a phase that is misplaced.

// File: rtl/lcs_pkg.sv
// Package lcs_pkg
// Shared types for the level-crossing step sequencer.
// Assumes: one controller clock domain.
package lcs_pkg;

    // Direction of a DAC step requested for the current edge
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;

endpackage

// File: rtl/lcs_sync.sv
// Module lcs_sync
// Multi-stage synchronizer for asynchronous comparator bits.
// Assumes: inputs are level signals held for at least one clock period;
// STAGES >= 2. Resets every stage to zero.
module lcs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw asynchronous value
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                // Later stages shift the value along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/lcs_dac_track.sv
// Module lcs_dac_track
// Saturating up/down register holding the DAC code.
// Assumes: at most one step request per cycle; the code never wraps.
module lcs_dac_track
    import lcs_pkg::*;
#(
    parameter int DAC_W     = 6,
    parameter int INIT_CODE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step,
    output logic [DAC_W-1:0] code
);

    localparam logic [DAC_W-1:0] CODE_MAX = '1;
    localparam logic [DAC_W-1:0] CODE_MIN = '0;
    localparam logic [DAC_W-1:0] CODE_RST = INIT_CODE[DAC_W-1:0];

    // Apply a one-step move, clamped at both ends of the range
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= CODE_RST;
        end else begin
            case (step)
                STEP_UP: if (code != CODE_MAX) code <= code + 1'b1;
                STEP_DN: if (code != CODE_MIN) code <= code - 1'b1;
                default: ;
            endcase
        end
    end

    // R3: a down step at the floor keeps the floor
    a_r3_floor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_DN && code == CODE_MIN) |=> (code == CODE_MIN));

    // R3: an up step at the ceiling keeps the ceiling
    a_r3_ceil_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_UP && code == CODE_MAX) |=> (code == CODE_MAX));

endmodule

// File: rtl/lcs_phase_gen.sv
// Module lcs_phase_gen
// Gated-oscillator model and edge counter: runs SEQ cycles after a start
// and forms NPH registered, non-overlapping phases with GAP idle cycles
// before each one.
// Assumes: start is only raised while run is low; GAP >= 1, PH_LEN >= 1.
module lcs_phase_gen #(
    parameter int PH_LEN = 3,
    parameter int GAP    = 1,
    parameter int NPH    = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           run,
    output logic [NPH-1:0] ph
);

    localparam int SLOT  = PH_LEN + GAP;
    localparam int SEQ   = NPH * SLOT + GAP;
    localparam int CNT_W = $clog2(SEQ);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SEQ - 1);

    logic [CNT_W-1:0] cnt, cnt_n;
    logic             run_n;
    logic [NPH-1:0]   ph_n;

    // Next count and gate: load on start, advance while running, stop at end
    always_comb begin
        run_n = run;
        cnt_n = cnt;
        if (start) begin
            run_n = 1'b1;
            cnt_n = '0;
        end else if (run) begin
            if (cnt == CNT_LAST) begin
                run_n = 1'b0;
                cnt_n = '0;
            end else begin
                cnt_n = cnt + 1'b1;
            end
        end
    end

    generate
        for (genvar k = 0; k < NPH; k++) begin : g_phase
            localparam logic [CNT_W-1:0] LO = CNT_W'(k * SLOT + GAP);
            localparam logic [CNT_W-1:0] HI = CNT_W'(k * SLOT + GAP + PH_LEN);
            // Window decode of phase k from the next count value
            always_comb ph_n[k] = run_n && (cnt_n >= LO) && (cnt_n < HI);
        end
    endgenerate

    // Register gate, count and phases so that the phase outputs are glitch-free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
            ph  <= '0;
        end else begin
            run <= run_n;
            cnt <= cnt_n;
            ph  <= ph_n;
        end
    end

    // R5: phases never overlap
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ph));

    // R6: no phase activity while the oscillator is gated off
    a_r6_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (ph == '0));

    // R4: a run ends only after the final count
    a_r4_full_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> ($past(cnt) == CNT_LAST));

endmodule

// File: rtl/lcs_ctrl.sv
// Module lcs_ctrl (top)
// Level-crossing converter controller: synchronizes the two comparator
// outputs, starts one step sequence per served crossing, emits the event
// pulse, steps the DAC code, and re-arms after the final reset phase so
// that a comparator held high keeps producing events.
// Assumes: comparator outputs are asynchronous levels; up wins over down.
module lcs_ctrl
    import lcs_pkg::*;
#(
    parameter int DAC_W       = 6,
    parameter int INIT_CODE   = 32,
    parameter int PH_LEN      = 3,
    parameter int GAP         = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_up_a,
    input  logic             cmp_dn_a,
    output logic             osc_en,
    output logic             ph_ref,
    output logic             ph_ofs,
    output logic             ph_norm,
    output logic             ph_rst,
    output logic [DAC_W-1:0] dac_code,
    output logic             ev_up,
    output logic             ev_dn
);

    localparam int NPH = 4;
    localparam logic [DAC_W-1:0] CODE_MAX = '1;
    localparam logic [DAC_W-1:0] CODE_MIN = '0;

    logic [1:0]     cmp_s;
    logic           up_s, dn_s;
    logic           start;
    step_e          step;
    logic [NPH-1:0] ph;

    lcs_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cmp_dn_a, cmp_up_a}),
        .q     (cmp_s)
    );

    assign up_s = cmp_s[0];
    assign dn_s = cmp_s[1];

    // Serve a crossing only from idle; up has priority when both are raised
    always_comb begin
        start = !osc_en && (up_s || dn_s);
        if (!start)    step = STEP_NONE;
        else if (up_s) step = STEP_UP;
        else           step = STEP_DN;
    end

    lcs_phase_gen #(
        .PH_LEN (PH_LEN),
        .GAP    (GAP),
        .NPH    (NPH)
    ) phase_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .run   (osc_en),
        .ph    (ph)
    );

    lcs_dac_track #(
        .DAC_W     (DAC_W),
        .INIT_CODE (INIT_CODE)
    ) dac_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .code  (dac_code)
    );

    assign ph_ref  = ph[0];
    assign ph_ofs  = ph[1];
    assign ph_norm = ph[2];
    assign ph_rst  = ph[3];

    // One-cycle event pulse on the edge that starts the sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_up <= 1'b0;
            ev_dn <= 1'b0;
        end else begin
            ev_up <= (step == STEP_UP);
            ev_dn <= (step == STEP_DN);
        end
    end

    // R1: an up event moves the code one step up below the ceiling
    a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_up && $past(dac_code) != CODE_MAX) |-> (dac_code == $past(dac_code) + 1'b1));

    // R2: a down event moves the code one step down above the floor
    a_r2_dn_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_dn && $past(dac_code) != CODE_MIN) |-> (dac_code == $past(dac_code) - 1'b1));

    // R8: never both directions in one sequence
    a_r8_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_up && ev_dn));

    // R4: every event coincides with the oscillator gate rising
    a_r4_ev_opens_osc: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_up || ev_dn) |-> $rose(osc_en));

    // R4: the oscillator gate only rises together with an event
    a_r4_osc_needs_ev: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> (ev_up || ev_dn));

    // R10: the code is frozen while a sequence is in progress
    a_r10_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && $past(osc_en)) |-> $stable(dac_code));

endmodule

// File: tb/lcs_ctrl_tb_top.sv
// Bench for lcs_ctrl: driver tasks queue the expected events with the cycle
// on which each is due, a monitor pops and compares them and also checks
// gate and phase levels on every cycle.
module lcs_ctrl_tb_top;

    localparam int CLK_T     = 10;
    localparam int DAC_W     = 6;
    localparam int INIT_CODE = 32;
    localparam int PH_LEN    = 3;
    localparam int GAP       = 1;
    localparam int SLOT      = PH_LEN + GAP;
    localparam int SEQ       = 4 * SLOT + GAP;
    localparam int LAT       = 3;
    localparam int CMAX      = (1 << DAC_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmp_up_a = 1'b0;
    logic             cmp_dn_a = 1'b0;
    logic             osc_en, ph_ref, ph_ofs, ph_norm, ph_rst, ev_up, ev_dn;
    logic [DAC_W-1:0] dac_code;

    lcs_ctrl #(
        .DAC_W       (DAC_W),
        .INIT_CODE   (INIT_CODE),
        .PH_LEN      (PH_LEN),
        .GAP         (GAP),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_up_a (cmp_up_a),
        .cmp_dn_a (cmp_dn_a),
        .osc_en   (osc_en),
        .ph_ref   (ph_ref),
        .ph_ofs   (ph_ofs),
        .ph_norm  (ph_norm),
        .ph_rst   (ph_rst),
        .dac_code (dac_code),
        .ev_up    (ev_up),
        .ev_dn    (ev_dn)
    );

    always #(CLK_T/2) clk = ~clk;

    typedef struct {
        bit up;
        int code;
        int due;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    int   mcode = INIT_CODE;
    int   last_ev = -100000;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // Queue one expected event due at cycle 'at', with the saturated model code
    task automatic push_ev(input bit up, input int at);
        exp_t e;
        if (up) mcode = (mcode == CMAX) ? CMAX : mcode + 1;
        else    mcode = (mcode == 0)    ? 0    : mcode - 1;
        e.up = up; e.code = mcode; e.due = at;
        q.push_back(e);
    endtask

    // One-cycle comparator pulse; up wins if both are raised (R1, R2, R8)
    task automatic pulse(input bit u, input bit d);
        @(negedge clk);
        cmp_up_a = u; cmp_dn_a = d;
        if (u || d) push_ev(u, cyc + LAT);
        @(negedge clk);
        cmp_up_a = 1'b0; cmp_dn_a = 1'b0;
        repeat (SEQ + 4) @(negedge clk);
    endtask

    // Hold one comparator high for n cycles; expect a retrigger every SEQ+1 (R7)
    task automatic hold(input bit u, input int n);
        int k, m;
        @(negedge clk);
        k = cyc;
        if (u) cmp_up_a = 1'b1; else cmp_dn_a = 1'b1;
        m = k + n;
        for (int s = k + LAT; s - 2 <= m; s += SEQ + 1) push_ev(u, s);
        repeat (n) @(negedge clk);
        cmp_up_a = 1'b0; cmp_dn_a = 1'b0;
        repeat (SEQ + 6) @(negedge clk);
    endtask

    // Monitor: event scoreboard plus per-cycle gate/phase expectation
    always @(negedge clk) begin
        if (mon_on) begin
            int off;
            logic [3:0] ph_exp, ph_act;
            if (ev_up || ev_dn) begin
                last_ev = cyc;
                if (q.size() == 0) begin
                    chk(1'b0, "R10 unexpected event", int'(ev_up), 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(ev_up == e.up && ev_dn == !e.up, e.up ? "R1 direction" : "R2 direction",
                        int'(ev_up), int'(e.up));
                    chk(int'(dac_code) == e.code, "R3 code after step", int'(dac_code), e.code);
                    chk(cyc == e.due, "R1 event latency", cyc, e.due);
                end
            end
            off = cyc - last_ev;
            for (int k = 0; k < 4; k++)
                ph_exp[k] = (off < SEQ) && (off >= k * SLOT + GAP) && (off < k * SLOT + GAP + PH_LEN);
            ph_act = {ph_rst, ph_norm, ph_ofs, ph_ref};
            if (off < SEQ) begin
                chk(osc_en == 1'b1, "R4 osc gate", int'(osc_en), 1);
                chk(ph_act == ph_exp, "R5 phase pattern", int'(ph_act), int'(ph_exp));
            end else begin
                chk(osc_en == 1'b0 && ph_act == 4'b0, "R6 idle quiet",
                    int'({osc_en, ph_act}), 0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog at cycle %0d: actual=1 expected=0", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk(int'(dac_code) == INIT_CODE, "R9 reset code", int'(dac_code), INIT_CODE);
        chk({osc_en, ph_ref, ph_ofs, ph_norm, ph_rst, ev_up, ev_dn} == 7'b0, "R9 reset outputs",
            int'({osc_en, ph_ref, ph_ofs, ph_norm, ph_rst, ev_up, ev_dn}), 0);
        mon_on = 1'b1;
        repeat (5) @(negedge clk);   // R6: idle with no stimulus

        // R1: single up crossings
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
        // R2: single down crossings
        for (int i = 0; i < 2; i++) pulse(1'b0, 1'b1);
        // R8: both at once, only up served
        pulse(1'b1, 1'b1);

        // R10: down pulse arriving mid-sequence is dropped
        @(negedge clk);
        cmp_up_a = 1'b1;
        push_ev(1'b1, cyc + LAT);
        @(negedge clk);
        cmp_up_a = 1'b0;
        repeat (5) @(negedge clk);
        cmp_dn_a = 1'b1;
        @(negedge clk);
        cmp_dn_a = 1'b0;
        repeat (SEQ + 6) @(negedge clk);
        chk(int'(dac_code) == mcode, "R10 code unchanged", int'(dac_code), mcode);

        // R7: stuck comparator keeps producing events
        hold(1'b1, 40);
        hold(1'b0, 20);

        // R3: drive to the ceiling and beyond, then to the floor and beyond
        while (mcode < CMAX) pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        chk(int'(dac_code) == CMAX, "R3 ceiling", int'(dac_code), CMAX);
        while (mcode > 0) pulse(1'b0, 1'b1);
        pulse(1'b0, 1'b1);
        pulse(1'b0, 1'b1);
        chk(int'(dac_code) == 0, "R3 floor", int'(dac_code), 0);

        repeat (10) @(negedge clk);
        chk(q.size() == 0, "R1 missing events", q.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule